// File: doc/BRIEF.md
# Comma-Aligning Serial-to-Parallel Character Converter

This block receives a recovered serial bit stream, one bit on each bit-clock edge, and assembles it into 10-bit parallel characters. A single-cycle strobe marks each finished character. When alignment is switched on, the block watches for a 7-bit comma sequence. If that sequence turns up anywhere other than the first seven bit slots of a character, including across a character boundary, the block moves its character boundary so that the comma opens a character. The character that holds the comma is flagged with a one-strobe pulse.

When alignment is switched off, the boundary in use is kept no matter what the data holds. A link-idle flag reports a dead line, meaning the last twenty received bits are identical. A loopback-mode input masks that flag.

Top module: `comma_deser`

## Requirements
- R1: While `rst_n` is low, `char_out`, `char_strobe`, `comma_flag` and `link_idle` are all 0. The bit sampled on the first clock edge after reset is bit 0 of the first character. Without realignment, `char_strobe` is first high after the edge that samples the tenth bit.
- R2: Without realignment, `char_strobe` is high for exactly one cycle after every tenth sampled bit. During that cycle `char_out[i]` holds the i-th bit of the character, where bit 0 is the earliest received.
- R3: The comma is the arrival sequence 0,0,1,1,1,1,1, earliest bit first. A comma that occupies character bits 0 to 6 is recognised but does not change the strobe spacing.
- R4: With `align_en` high, a comma at any other offset, including one split across two characters, restarts the boundary at the comma's first bit. The partial character is discarded with no strobe. The next strobe follows the third bit after the comma, and 10-bit spacing resumes from there.
- R5: `comma_flag` is high only together with `char_strobe`, and only for the character whose bits 0 to 6 hold the comma. That means `char_out[6:0]` = 7'b1111100 (bit 0 = 0).
- R6: With `align_en` low, a comma at a wrong offset neither moves the boundary nor raises `comma_flag`. Strobes stay exactly 10 cycles apart.
- R7: After the edge that samples a bit, `link_idle` is high when at least 20 bits have been received since reset, the last 20 bits are all 0 or all 1, and `loopback` is low.
- R8: `loopback` high forces `link_idle` low at once, in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Recovered serial data bit |
| align_en | input | 1 | High allows realignment on a misplaced comma |
| loopback | input | 1 | Loopback mode; high masks the idle flag |
| char_out | output | CHAR_W | Parallel character, bit 0 received first |
| char_strobe | output | 1 | One-cycle pulse marking a new character |
| comma_flag | output | 1 | Marks the character that holds an aligned comma |
| link_idle | output | 1 | Last 20 bits identical and loopback low |

## Verification
Some rules are checked on every cycle:
- strobes are never adjacent;
- a comma flag never appears without a strobe, and only over the comma bit pattern;
- loopback always masks the idle flag;
- an idle flag coinciding with a strobe implies a uniform character;
- while `align_en` stays low, strobe spacing is exactly ten.

Other behaviour needs the bench's bit-accurate model driven through its scenarios:
- the exact strobe cycle after realignment, and the dropped partial character;
- which offsets count as misaligned, including straddling commas;
- the bit order within a character;
- the idle flag's 20-bit fill rule after reset.

// File: rtl/comma_deser_pkg.sv
`timescale 1ns/1ps
// Shared constants for the comma-aligning converter.
package comma_deser_pkg;
    // Character width in bits.
    localparam int unsigned CHAR_W = 10;
    // Comma length in bits.
    localparam int unsigned MARK_W = 7;
    // Comma in a newest-at-bit-0 window: MSB is the earliest bit (0,0,1,1,1,1,1).
    localparam logic [MARK_W-1:0] MARK_PAT = 7'b0011111;
    // Same comma as it appears in char_out[MARK_W-1:0] (bit 0 earliest).
    localparam logic [MARK_W-1:0] MARK_ORD = 7'b1111100;
endpackage

// File: rtl/comma_finder.sv
`timescale 1ns/1ps
// comma_finder: keeps the newest HIST_W received bits (newest at bit 0)
// and reports a comma ending on the bit being sampled this edge.
// Assumes one valid bit per clock and HIST_W >= MARK_W.
module comma_finder
    import comma_deser_pkg::*;
#(
    parameter int unsigned HIST_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic [HIST_W-1:0] win,
    output logic              mark_hit,
    output logic              hist_full
);
    localparam int unsigned        FILL_W     = $clog2(HIST_W + 1);
    localparam logic [FILL_W-1:0]  FILL_MAX   = FILL_W'(HIST_W);
    localparam logic [FILL_W-1:0]  MARK_READY = FILL_W'(MARK_W - 1);
    localparam logic [FILL_W-1:0]  HIST_READY = FILL_W'(HIST_W - 1);

    logic [HIST_W-1:0] hist_q;
    logic [FILL_W-1:0] fill_q;

    // Window including the bit being sampled now.
    assign win = {hist_q[HIST_W-2:0], ser_in};

    // Comma ends on the current bit; only counts after MARK_W real bits.
    assign mark_hit  = (fill_q >= MARK_READY) && (win[MARK_W-1:0] == MARK_PAT);
    // After this edge, HIST_W real bits will have been received.
    assign hist_full = (fill_q >= HIST_READY);

    // Shift history and count received bits up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            fill_q <= '0;
        end else begin
            hist_q <= win;
            if (fill_q != FILL_MAX) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/frame_counter.sv
`timescale 1ns/1ps
// frame_counter: tracks the bit index within the current character,
// restarts the boundary on a misplaced comma when alignment is enabled,
// and remembers an aligned comma until its character is emitted.
// Assumes MARK_W < CHAR_W.
module frame_counter
    import comma_deser_pkg::*;
#(
    parameter int unsigned CHAR_W_P = CHAR_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark_hit,
    input  logic align_en,
    output logic emit,
    output logic emit_mark
);
    localparam int unsigned      CNT_W    = $clog2(CHAR_W_P);
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(CHAR_W_P - 1);
    localparam logic [CNT_W-1:0] MARK_END = CNT_W'(MARK_W - 1);
    localparam logic [CNT_W-1:0] RESTART  = CNT_W'(MARK_W);

    logic [CNT_W-1:0] idx_q;
    logic             pend_q;
    logic             at_mark_end;
    logic             realign;
    logic             aligned_hit;

    // Decide realignment, emission and aligned-comma capture for this bit.
    always_comb begin
        at_mark_end = (idx_q == MARK_END);
        realign     = mark_hit && align_en && !at_mark_end;
        emit        = (idx_q == LAST) && !realign;
        aligned_hit = mark_hit && (at_mark_end || realign);
    end

    assign emit_mark = emit && pend_q;

    // Advance the bit index and hold the pending comma marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (realign) begin
                idx_q <= RESTART;
            end else if (idx_q == LAST) begin
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
            if (emit) begin
                pend_q <= 1'b0;
            end else if (aligned_hit) begin
                pend_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/char_emitter.sv
`timescale 1ns/1ps
// char_emitter: registers a finished character in arrival order
// (bit 0 earliest) with its strobe and comma flag.
// Assumes win_char holds the newest CHAR_W bits, newest at bit 0.
module char_emitter #(
    parameter int unsigned CHAR_W_P = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                emit,
    input  logic                emit_mark,
    input  logic [CHAR_W_P-1:0] win_char,
    output logic [CHAR_W_P-1:0] char_out,
    output logic                char_strobe,
    output logic                comma_flag
);
    logic [CHAR_W_P-1:0] ordered;

    // Reverse the window so the earliest bit lands at bit 0.
    for (genvar i = 0; i < CHAR_W_P; i++) begin : g_order
        assign ordered[i] = win_char[CHAR_W_P-1-i];
    end

    // Capture the character on emit; strobe and flag last one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_out    <= '0;
            char_strobe <= 1'b0;
            comma_flag  <= 1'b0;
        end else begin
            char_strobe <= emit;
            comma_flag  <= emit_mark;
            if (emit) begin
                char_out <= ordered;
            end
        end
    end
endmodule

// File: rtl/idle_detect.sv
`timescale 1ns/1ps
// idle_detect: flags a line whose last HIST_W bits are identical;
// loopback mode masks the flag combinationally.
// Assumes hist_full marks that the window holds only received bits.
module idle_detect #(
    parameter int unsigned HIST_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] win,
    input  logic              hist_full,
    input  logic              loopback,
    output logic              link_idle
);
    logic idle_q;

    // Register the uniform-window condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= 1'b0;
        end else begin
            idle_q <= hist_full && ((~|win) || (&win));
        end
    end

    assign link_idle = idle_q && !loopback;
endmodule

// File: rtl/comma_deser.sv
`timescale 1ns/1ps
// comma_deser: serial-to-parallel character converter with comma
// alignment and idle detection. One bit per clock on ser_in.
// Assumes a bit arrives on every clock edge after reset.
module comma_deser
    import comma_deser_pkg::*;
#(
    parameter int unsigned CHAR_W_P = CHAR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_in,
    input  logic                align_en,
    input  logic                loopback,
    output logic [CHAR_W_P-1:0] char_out,
    output logic                char_strobe,
    output logic                comma_flag,
    output logic                link_idle
);
    localparam int unsigned HIST_W = 2 * CHAR_W_P;

    logic [HIST_W-1:0] win;
    logic              mark_hit;
    logic              hist_full;
    logic              emit;
    logic              emit_mark;

    comma_finder #(.HIST_W(HIST_W)) u_find (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
        .win(win), .mark_hit(mark_hit), .hist_full(hist_full)
    );

    frame_counter #(.CHAR_W_P(CHAR_W_P)) u_frame (
        .clk(clk), .rst_n(rst_n), .mark_hit(mark_hit), .align_en(align_en),
        .emit(emit), .emit_mark(emit_mark)
    );

    char_emitter #(.CHAR_W_P(CHAR_W_P)) u_emit (
        .clk(clk), .rst_n(rst_n), .emit(emit), .emit_mark(emit_mark),
        .win_char(win[CHAR_W_P-1:0]), .char_out(char_out),
        .char_strobe(char_strobe), .comma_flag(comma_flag)
    );

    idle_detect #(.HIST_W(HIST_W)) u_idle (
        .clk(clk), .rst_n(rst_n), .win(win), .hist_full(hist_full),
        .loopback(loopback), .link_idle(link_idle)
    );
endmodule

// File: rtl/comma_deser_chk.sv
`timescale 1ns/1ps
// comma_deser_chk: cycle-level properties of comma_deser, bound below.
module comma_deser_chk
    import comma_deser_pkg::*;
#(
    parameter int unsigned CHAR_W_P = CHAR_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                align_en,
    input logic                loopback,
    input logic [CHAR_W_P-1:0] char_out,
    input logic                char_strobe,
    input logic                comma_flag,
    input logic                link_idle
);
    localparam logic [7:0] GAP_EXP = 8'(CHAR_W_P);

    logic [7:0] gap_q;
    logic       en_seen_q;
    logic       seen_q;

    // Measure strobe spacing and note any cycle with alignment enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q     <= '0;
            en_seen_q <= 1'b0;
            seen_q    <= 1'b0;
        end else if (char_strobe) begin
            gap_q     <= 8'd1;
            en_seen_q <= align_en;
            seen_q    <= 1'b1;
        end else begin
            if (gap_q != 8'hff) gap_q <= gap_q + 1'b1;
            en_seen_q <= en_seen_q || align_en;
        end
    end

    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        char_strobe |=> !char_strobe);

    a_r5_flag_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        comma_flag |-> char_strobe);

    a_r5_flag_content: assert property (@(posedge clk) disable iff (!rst_n)
        comma_flag |-> (char_out[MARK_W-1:0] == MARK_ORD));

    a_r8_loopback_masks: assert property (@(posedge clk) disable iff (!rst_n)
        loopback |-> !link_idle);

    a_r7_idle_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (link_idle && char_strobe) |-> ((char_out == '0) || (char_out == '1)));

    a_r6_hold_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (char_strobe && seen_q && !en_seen_q) |-> (gap_q == GAP_EXP));
endmodule

bind comma_deser comma_deser_chk #(.CHAR_W_P(CHAR_W_P)) u_chk (
    .clk(clk), .rst_n(rst_n), .align_en(align_en), .loopback(loopback),
    .char_out(char_out), .char_strobe(char_strobe),
    .comma_flag(comma_flag), .link_idle(link_idle)
);

// File: tb/comma_deser_test.sv
`timescale 1ns/1ps
module comma_deser_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       align_en = 1'b0;
    logic       loopback = 1'b0;
    logic [9:0] char_out;
    logic       char_strobe;
    logic       comma_flag;
    logic       link_idle;

    int  total = 0;
    int  bad = 0;
    bit  done = 0;
    string tag = "R1";
    bit  cfg_align = 0;
    bit  cfg_loop = 0;

    // Reference model state (from the requirements).
    logic [19:0] mh = '0;
    int  mfill = 0;
    int  mcnt = 0;
    bit  mpend = 0;
    bit  exp_valid = 0;
    bit  exp_flag = 0;
    logic [9:0] exp_char = '0;
    bit  m_idle = 0;

    always #2.5 clk = ~clk;

    comma_deser uut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .align_en(align_en),
        .loopback(loopback), .char_out(char_out), .char_strobe(char_strobe),
        .comma_flag(comma_flag), .link_idle(link_idle)
    );

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
        end
    endtask

    function automatic bit is_comma(input logic [19:0] h);
        return h[6:0] == 7'b0011111;
    endfunction

    task automatic step(input logic b);
        logic [19:0] nh;
        bit hit, realign, emit, ah;
        nh = {mh[18:0], b};
        hit = (mfill >= 6) && is_comma(nh);
        realign = hit && cfg_align && (mcnt != 6);
        emit = (mcnt == 9) && !realign;
        ah = hit && ((mcnt == 6) || realign);
        exp_valid = emit;
        exp_flag = emit && mpend;
        if (emit) for (int i = 0; i < 10; i++) exp_char[i] = nh[9-i];
        if (emit) mpend = 0; else if (ah) mpend = 1;
        mcnt = realign ? 7 : ((mcnt == 9) ? 0 : mcnt + 1);
        if (mfill < 20) mfill++;
        m_idle = (mfill >= 20) && ((nh == '0) || (nh == '1));
        mh = nh;
    endtask

    task automatic compare();
        check(char_strobe == exp_valid, "strobe", char_strobe, exp_valid);
        check(link_idle == (m_idle && !loopback), "R7/R8 idle", link_idle,
              m_idle && !loopback);
        if (exp_valid) begin
            check(char_out == exp_char, "char", char_out, exp_char);
            check(comma_flag == exp_flag, "R5 flag", comma_flag, exp_flag);
        end else begin
            check(comma_flag == 1'b0, "R5 flag idle", comma_flag, 0);
        end
    endtask

    // Drive one bit at a falling edge, then compare one cycle later.
    task automatic send_bit(input logic b);
        align_en = cfg_align;
        loopback = cfg_loop;
        ser_in = b;
        step(b);
        @(negedge clk);
        compare();
    endtask

    task automatic send_rand(input int n);
        for (int i = 0; i < n; i++) send_bit(1'($urandom));
    endtask

    task automatic send_run(input logic v, input int n);
        for (int i = 0; i < n; i++) send_bit(v);
    endtask

    task automatic send_comma();
        send_bit(0); send_bit(0);
        for (int i = 0; i < 5; i++) send_bit(1);
        send_bit(0); send_bit(1); send_bit(0);
    endtask

    // Pad with bits that cannot form a comma, so the comma starts at index pos.
    task automatic pad_to(input int pos);
        while (mcnt != pos) send_bit(0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1: reset values
        check(char_out == '0 && !char_strobe && !comma_flag && !link_idle,
              "R1 reset outputs", {char_out, char_strobe, comma_flag, link_idle}, 0);
        rst_n = 1'b1;

        tag = "R1";
        for (int i = 0; i < 9; i++) send_bit(1'($urandom));
        check(char_strobe == 1'b0, "R1 no strobe before bit 10", char_strobe, 0);
        send_bit(1);
        check(char_strobe == 1'b1, "R1 strobe after bit 10", char_strobe, 1);

        tag = "R2";
        send_rand(200);

        tag = "R3";
        cfg_align = 1;
        for (int k = 0; k < 4; k++) begin
            pad_to(0);
            send_comma();
            send_rand(13);
        end

        tag = "R4";
        for (int off = 1; off < 10; off++) begin
            pad_to(off);
            send_comma();
            send_rand(17);
        end

        tag = "R6";
        cfg_align = 0;
        for (int off = 1; off < 10; off++) begin
            pad_to(off);
            send_comma();
            send_rand(11);
        end

        tag = "R7";
        send_run(0, 25);
        send_run(1, 25);
        send_bit(0);
        send_run(1, 22);

        tag = "R8";
        cfg_loop = 1;
        send_run(0, 25);
        cfg_loop = 0;
        send_run(0, 3);
        cfg_loop = 1;
        send_bit(0);
        cfg_loop = 0;

        tag = "R5";
        for (int i = 0; i < 400; i++) begin
            cfg_align = ($urandom % 4) != 0;
            cfg_loop = ($urandom % 8) == 0;
            case ($urandom % 4)
                0: send_comma();
                1: send_run(1'($urandom), 5 + ($urandom % 20));
                default: send_rand(1 + ($urandom % 12));
            endcase
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog %s act=hung exp=finished", tag);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule